// File: doc/BRIEF.md
# Add-Then-Operate Execute Core

This block is a single-issue execute core for 32-bit instruction words. Each cycle it presents a fetch address, takes the instruction word returned for that address, and executes it completely. The operand path is the same for every arithmetic instruction: the source-2 register is first summed with the sign-extended 16-bit immediate, and the main operation then combines source 1 with that sum. The core has no register-versus-immediate select. A program chooses a register operand by giving a zero immediate, or an immediate operand by naming register 0.

The core has sixteen 32-bit registers. Register 0 always reads zero. Register 1 is the program counter, counted in whole instruction words. It is an ordinary writable destination, so writing it is how a program jumps. Each executed instruction is also shown on a writeback port in the cycle it executes. An integrating design uses this port to follow results, and the bench uses it to observe register contents.

Instruction layout: opcode[31:28], dst[27:24], src1[23:20], src2[19:16], imm[15:0]. Opcodes: 0000 no-operation, 0001 add, 0010 subtract, 0011 and, 0100 or, 0101 xor, 1000 multiply, 1111 halt. Every other opcode behaves as a no-operation.

Top module: `exec_core`

## Requirements
- R1: While rstN is low, instrAddr is 0 (RESET_PC) and halted is 0. After reset every register 2..15 reads zero.
- R2: Opcode 0001 writes dst = src1 + (src2 + sext(imm)), wrapping modulo 2^32.
- R3: Opcode 1000 writes dst = low 32 bits of src1 * (src2 + sext(imm)).
- R4: Opcodes 0010, 0011, 0100 and 0101 write src1 - b, src1 & b, src1 | b and src1 ^ b respectively, where b = src2 + sext(imm).
- R5: imm[15:0] is sign-extended from bit 15 before the add. For example, 0xFFFF adds -1.
- R6: Register 0 reads zero. An instruction with dst = 0 leaves wbEn low and changes no register.
- R7: Register 1 read as a source gives the address of the next instruction, which is instrAddr + 1.
- R8: An instruction with dst = 1 makes its result the next instrAddr. Adding 0 to register 1 falls through, adding 5 skips five words, adding -1 repeats the same instruction, and subtracting 2 returns to the previous instruction.
- R9: When no jump and no halt occurs, instrAddr increases by exactly 1 each cycle.
- R10: Opcode 0000 and every undefined opcode (for example 0110) write nothing and advance instrAddr by 1, whatever their other bits hold.
- R11: Opcode 1111 writes nothing. From the next cycle, halted is 1 and instrAddr stays on the halt word until reset.
- R12: In the cycle an instruction is presented, wbEn, wbReg and wbData show its destination and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrAddr | output | XLEN | Word address of the instruction to execute (register 1) |
| instrData | input | 32 | Instruction word returned for instrAddr in the same cycle |
| halted | output | 1 | High once a halt instruction has executed |
| wbEn | output | 1 | A register write happens at the coming edge |
| wbReg | output | 4 | Destination register of that write |
| wbData | output | XLEN | Value being written |

## Verification
The bench builds the core with its defaults, XLEN = 32 and RESET_PC = 0. A 64-word instruction store is wired combinationally to the fetch port. At 32 bits, products such as 0x3FFF0001 * 16 overflow, which makes the modulo wrap of R3 observable. Adding -1 to 0xFFFFFFFF likewise exercises the wrap of R2. Because the reset address is zero, the relative jumps of R8 land at addresses that can be computed directly inside the store, including the one-word self-loop and the backward step of two.

// File: rtl/exec_core_pkg.sv
package exec_core_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 4;
  localparam int NREG    = 1 << REG_W;
  localparam int IMM_W   = 16;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OP_NOP  = 4'b0000;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'b0010;
  localparam logic [OPC_W-1:0] OP_AND  = 4'b0011;
  localparam logic [OPC_W-1:0] OP_OR   = 4'b0100;
  localparam logic [OPC_W-1:0] OP_XOR  = 4'b0101;
  localparam logic [OPC_W-1:0] OP_MUL  = 4'b1000;
  localparam logic [OPC_W-1:0] OP_HALT = 4'b1111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_MUL
  } aluOpT;

  typedef struct packed {
    logic  wrEn;     // write result to dst
    logic  advance;  // update program counter this cycle
    aluOpT aluOp;
  } strobesT;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_core_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  output logic             haltedQ,
  output strobesT          strobes
);
  always_comb begin
    strobes = '{wrEn: 1'b0, advance: 1'b0, aluOp: ALU_ADD};
    if (!haltedQ) begin
      strobes.advance = 1'b1;
      unique case (opcode)
        OP_ADD:  begin strobes.wrEn = 1'b1; strobes.aluOp = ALU_ADD; end
        OP_SUB:  begin strobes.wrEn = 1'b1; strobes.aluOp = ALU_SUB; end
        OP_AND:  begin strobes.wrEn = 1'b1; strobes.aluOp = ALU_AND; end
        OP_OR:   begin strobes.wrEn = 1'b1; strobes.aluOp = ALU_OR;  end
        OP_XOR:  begin strobes.wrEn = 1'b1; strobes.aluOp = ALU_XOR; end
        OP_MUL:  begin strobes.wrEn = 1'b1; strobes.aluOp = ALU_MUL; end
        OP_HALT: strobes.advance = 1'b0;
        default: ; // no-operation and undefined codes
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) haltedQ <= 1'b0;
    else if (opcode == OP_HALT) haltedQ <= 1'b1;
  end
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_core_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  strobesT            strobes,
  output logic [XLEN-1:0]    pc,
  output logic               wbEn,
  output logic [REG_W-1:0]   wbReg,
  output logic [XLEN-1:0]    wbData
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam logic [REG_W-1:0] PC_IDX = REG_W'(1);

  logic [REG_W-1:0] dstIdx, src1Idx, src2Idx;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  immExt, pcPlus1, opA, opB, result;
  logic [XLEN-1:0]  regView [NREG];

  assign dstIdx  = instr[27:24];
  assign src1Idx = instr[23:20];
  assign src2Idx = instr[19:16];
  assign imm     = instr[IMM_W-1:0];
  assign immExt  = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign pcPlus1 = pc + XLEN'(1);

  assign wbEn   = strobes.wrEn && (dstIdx != '0);
  assign wbReg  = dstIdx;
  assign wbData = result;

  // Register 0 is a constant, register 1 is the program counter,
  // the rest are plain flops.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regView[i] = '0;
    end else if (i == 1) begin : g_pc
      assign regView[i] = pcPlus1;
    end else begin : g_flop
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (wbEn && dstIdx == REG_W'(i)) q <= result;
      end
      assign regView[i] = q;
    end
  end

  assign opA = regView[src1Idx];
  assign opB = regView[src2Idx] + immExt;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      ALU_MUL: result = opA * opB;
      default: result = opA + opB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pc <= RESET_PC;
    else if (strobes.advance) pc <= (wbEn && dstIdx == PC_IDX) ? result : pcPlus1;
  end
endmodule

// File: rtl/exec_core.sv
module exec_core
  import exec_core_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [XLEN-1:0]    instrAddr,
  input  logic [INSTR_W-1:0] instrData,
  output logic               halted,
  output logic               wbEn,
  output logic [REG_W-1:0]   wbReg,
  output logic [XLEN-1:0]    wbData
);
  strobesT strobes;

  exec_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (instrData[31:28]),
    .haltedQ (halted),
    .strobes (strobes)
  );

  exec_datapath #(.XLEN(XLEN), .RESET_PC(RESET_PC)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .instr   (instrData),
    .strobes (strobes),
    .pc      (instrAddr),
    .wbEn    (wbEn),
    .wbReg   (wbReg),
    .wbData  (wbData)
  );
endmodule

// File: rtl/exec_core_checker.sv
module exec_core_checker
  import exec_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [XLEN-1:0]    instrAddr,
  input logic [INSTR_W-1:0] instrData,
  input logic               halted,
  input logic               wbEn,
  input logic [REG_W-1:0]   wbReg,
  input logic [XLEN-1:0]    wbData
);
  logic [OPC_W-1:0] opc;
  assign opc = instrData[31:28];

  assert_no_r0_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> wbReg != '0);

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && wbEn && wbReg == REG_W'(1)) |=> instrAddr == $past(wbData));

  assert_step_by_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && opc != OP_HALT && !(wbEn && wbReg == REG_W'(1)))
      |=> instrAddr == $past(instrAddr) + XLEN'(1));

  assert_nop_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opc == OP_NOP || opc == 4'b0110 || opc == 4'b0111) |-> !wbEn);

  assert_halt_enters_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && opc == OP_HALT) |=> halted && $stable(instrAddr));

  assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(instrAddr) && !wbEn);
endmodule

bind exec_core exec_core_checker #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rstN(rstN), .instrAddr(instrAddr), .instrData(instrData),
  .halted(halted), .wbEn(wbEn), .wbReg(wbReg), .wbData(wbData)
);

// File: tb/exec_core_tb.sv
module exec_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [XLEN-1:0] instrAddr;
  logic [31:0]     instrData;
  logic            halted, wbEn;
  logic [3:0]      wbReg;
  logic [XLEN-1:0] wbData;
  logic [31:0]     imem [64];

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign instrData = imem[instrAddr[5:0]];

  exec_core dut_i (
    .clk(clk), .rstN(rstN), .instrAddr(instrAddr), .instrData(instrData),
    .halted(halted), .wbEn(wbEn), .wbReg(wbReg), .wbData(wbData)
  );

  function automatic logic [31:0] enc(logic [3:0] op, logic [3:0] d,
      logic [3:0] s1, logic [3:0] s2, logic [15:0] imm);
    return {op, d, s1, s2, imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
  endtask

  task automatic startRun();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    #1;
  endtask

  task automatic checkWb(string req, logic [3:0] r, logic [31:0] v);
    check({req, " wbEn"}, 32'(wbEn), 32'd1);
    check({req, " wbReg"}, 32'(wbReg), 32'(r));
    check({req, " wbData"}, wbData, v);
  endtask

  task automatic testReset();
    clearMem();
    imem[0] = enc(4'b0001, 4'd2, 4'd3, 4'd15, 16'd0);
    rstN = 1'b0;
    step(); step();
    check("R1 addr in reset", instrAddr, 32'd0);
    check("R1 halted in reset", 32'(halted), 32'd0);
    rstN = 1'b1; #1;
    checkWb("R1 regs zero after reset", 4'd2, 32'd0);
  endtask

  task automatic testArith();
    clearMem();
    imem[0]  = enc(4'b0001, 4'd2,  4'd0,  4'd0,  16'd100);
    imem[1]  = enc(4'b0001, 4'd3,  4'd2,  4'd0,  16'hFFFF);
    imem[2]  = enc(4'b1000, 4'd4,  4'd2,  4'd3,  16'd1);
    imem[3]  = enc(4'b0010, 4'd5,  4'd4,  4'd2,  16'd0);
    imem[4]  = enc(4'b0001, 4'd6,  4'd0,  4'd0,  16'hFFFF);
    imem[5]  = enc(4'b1000, 4'd7,  4'd6,  4'd6,  16'd0);
    imem[6]  = enc(4'b0001, 4'd8,  4'd6,  4'd0,  16'd2);
    imem[7]  = enc(4'b0011, 4'd9,  4'd4,  4'd0,  16'h00FF);
    imem[8]  = enc(4'b0100, 4'd10, 4'd2,  4'd0,  16'h0F00);
    imem[9]  = enc(4'b0101, 4'd11, 4'd2,  4'd0,  16'd100);
    imem[10] = enc(4'b0001, 4'd12, 4'd0,  4'd0,  16'h7FFF);
    imem[11] = enc(4'b1000, 4'd13, 4'd12, 4'd12, 16'd0);
    imem[12] = enc(4'b1000, 4'd14, 4'd13, 4'd0,  16'd16);
    startRun();
    checkWb("R2 add imm", 4'd2, 32'd100);                  step();
    checkWb("R5 negative imm", 4'd3, 32'd99);              step();
    checkWb("R3 mul", 4'd4, 32'd10000);                    step();
    checkWb("R4 sub", 4'd5, 32'd9900);                     step();
    checkWb("R5 sext all ones", 4'd6, 32'hFFFF_FFFF);      step();
    checkWb("R3 mul negatives", 4'd7, 32'd1);              step();
    checkWb("R2 add wraps", 4'd8, 32'd1);                  step();
    checkWb("R4 and", 4'd9, 32'd16);                       step();
    checkWb("R4 or", 4'd10, 32'h0000_0F64);                step();
    checkWb("R4 xor", 4'd11, 32'd0);                       step();
    checkWb("R12 writeback", 4'd12, 32'd32767);            step();
    checkWb("R3 mul big", 4'd13, 32'h3FFF_0001);           step();
    checkWb("R3 mul low bits", 4'd14, 32'hFFF0_0010);
  endtask

  task automatic testZeroReg();
    clearMem();
    imem[0] = enc(4'b0001, 4'd0, 4'd0, 4'd0, 16'd5);
    imem[1] = enc(4'b0001, 4'd2, 4'd0, 4'd0, 16'd0);
    startRun();
    check("R6 no write to r0", 32'(wbEn), 32'd0);
    step();
    checkWb("R6 r0 still zero", 4'd2, 32'd0);
  endtask

  task automatic testFlow();
    clearMem();
    imem[0]  = enc(4'b0001, 4'd2, 4'd1, 4'd0, 16'd0);
    imem[1]  = enc(4'b0001, 4'd1, 4'd1, 4'd0, 16'd5);
    imem[7]  = enc(4'b0001, 4'd1, 4'd1, 4'd0, 16'd0);
    imem[8]  = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd0);
    imem[9]  = enc(4'b0110, 4'd3, 4'd2, 4'd2, 16'd9);
    imem[10] = enc(4'b0001, 4'd3, 4'd0, 4'd0, 16'd7);
    imem[11] = enc(4'b0010, 4'd1, 4'd1, 4'd0, 16'd2);
    startRun();
    checkWb("R7 r1 reads next addr", 4'd2, 32'd1);         step();
    check("R9 sequential step", instrAddr, 32'd1);
    checkWb("R8 jump value", 4'd1, 32'd7);                 step();
    check("R8 skip five", instrAddr, 32'd7);               step();
    check("R8 add zero falls through", instrAddr, 32'd8);
    check("R10 nop no write", 32'(wbEn), 32'd0);           step();
    check("R10 nop advances", instrAddr, 32'd9);
    check("R10 undefined no write", 32'(wbEn), 32'd0);     step();
    check("R10 undefined advances", instrAddr, 32'd10);    step();
    check("R9 sequential step", instrAddr, 32'd11);        step();
    check("R8 minus two goes back", instrAddr, 32'd10);
    checkWb("R8 previous re-executes", 4'd3, 32'd7);
  endtask

  task automatic testSelfLoop();
    clearMem();
    imem[0] = enc(4'b0001, 4'd1, 4'd1, 4'd0, 16'hFFFF);
    startRun();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8 minus one repeats", instrAddr, 32'd0);
    end
  endtask

  task automatic testHalt();
    clearMem();
    imem[0] = enc(4'b0001, 4'd2, 4'd0, 4'd0, 16'd1);
    imem[1] = enc(4'b1111, 4'd3, 4'd0, 4'd0, 16'd4);
    imem[2] = enc(4'b0001, 4'd4, 4'd0, 4'd0, 16'd2);
    startRun();
    step();
    check("R11 halt no write", 32'(wbEn), 32'd0);
    check("R11 not yet halted", 32'(halted), 32'd0);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R11 halted", 32'(halted), 32'd1);
      check("R11 fetch frozen", instrAddr, 32'd1);
    end
    startRun();
    check("R1 reset clears halt", 32'(halted), 32'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    testReset();
    testArith();
    testZeroReg();
    testFlow();
    testSelfLoop();
    testHalt();
    finishRun();
  end
endmodule